// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the byte-level control core of a serial NOR flash slave. The serial shifter in front of it hands over one whole byte per transfer while chip-select is active, and signals each new chip-select assertion with a one-cycle pulse. The first byte after that pulse is taken as an opcode. The sequencer then collects the address bytes and any mode bytes, waits out the dummy bytes where the command needs them, and moves into one of three phases: array read, array program, or register read.

A memory-array back end sits behind the sequencer. It answers reads combinationally on a byte-wide read port. It also accepts byte writes and erase-region requests. The erase request names a base address and a length, and the back end fills that region with 0xFF. For every byte received, the sequencer returns one response byte. The response register holds 0xFF whenever no data phase is active.

The data-line count (1, 2 or 4) and the I/O-header class come in as static inputs. Together they set how many dummy bytes are needed and how long the dual-I/O and quad-I/O headers are.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the sequencer is idle, write enable is clear, 3-byte addressing is active, the extended-address register is 0 and `resp_out` is 0xFF.
- R2: A `cs_start` pulse returns the sequencer to idle from any phase. The next byte is decoded as an opcode and the write-enable latch is kept.
- R3: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Status read 0x05 returns a byte with write enable in bit 1 and all other bits 0. It repeats that byte on every transfer until the next `cs_start`.
- R4: Opcode 0x9F returns the 24-bit ID most significant byte first, followed by the 16-bit extended ID most significant byte first when it is present. After the last byte the sequencer is idle again and decodes the next byte as an opcode.
- R5: Read 0x03 takes 3 address bytes, or 4 when 4-byte mode is on. Read 0x13 always takes 4. Opcode 0xB7 enters 4-byte mode and 0xE9 leaves it. Address bytes come most significant first. Data for the address appears on the transfer right after the last address byte. The address then increments and wraps to 0 past 2^MEM_AW-1.
- R6: With write enable set, opcode 0xC5 followed by one byte loads the extended-address register. Opcode 0xC8 returns that register once. With 3-byte addressing, the register's low 2 bits times 0x1000000 are added to the address.
- R7: Fast reads (0x0B, 0x3B, 0x6B, 3 or 4 address bytes; 0x0C, 0x3C, 0x6C, always 4) and the I/O reads insert dummy transfers before data. There is one dummy transfer for `lanes`=0 (single line), two for `lanes`=1 (dual) and four for `lanes`=2 or 3 (quad). Each dummy transfer returns 0xFF.
- R8: Dual-I/O read 0xBB collects 4 header bytes when `wide_io_hdr`=0 and 5 when it is 1. Quad-I/O read 0xEB collects 6 or 8. The 4-byte forms 0xBC and 0xEC collect one byte more and always use a 4-byte address. The address is the first 3 or 4 header bytes, and the remaining header bytes are ignored.
- R9: Program opcodes 0x02, 0x32 and 0xA2 take 3 or 4 address bytes, and 0x12 and 0x34 always take 4. Each later byte is written at the current address, which then increments. Without write enable no write strobe is issued.
- R10: With write enable set, an erase pulses `erase_req` for one cycle after its last address byte. Opcodes 0x20 and 0x21 erase 4096 bytes, 0x52 erases 32768, and 0xD8 and 0xDC erase 2^SECT_LOG2 bytes. Chip erase 0x60 or 0xC7 pulses `erase_req` right after the opcode with base 0 and length 2^MEM_AW. Without write enable no request is made.
- R11: An unknown opcode returns 0xFF and leaves the sequencer idle, so the next byte is decoded as an opcode.
- R12: `resp_out` is registered. It holds 0xFF during opcode, address, header, dummy and program transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_start | input | 1 | One-cycle pulse at chip-select assertion |
| byte_valid | input | 1 | A received byte is present on `byte_in` |
| byte_in | input | 8 | Received byte |
| lanes | input | 2 | Active data lines: 0 single, 1 dual, 2/3 quad |
| wide_io_hdr | input | 1 | Selects the longer dual/quad-I/O header class |
| resp_out | output | 8 | Response byte for the last transfer |
| mem_rd_en | output | 1 | Array read strobe |
| mem_wr_en | output | 1 | Array write strobe |
| mem_addr | output | 32 | Current array address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Combinational array read data |
| erase_req | output | 1 | One-cycle erase request |
| erase_base | output | 32 | Erase start address |
| erase_len | output | 32 | Erase length in bytes |

## Verification
The response to the byte taken at a rising edge sits in `resp_out` right after that same edge. The erase request and its base and length appear at the same moment and last exactly one cycle. The write strobe, address and data are combinational during the cycle the byte is presented, so the bench model latches them at the consuming edge. The bench changes inputs on falling edges and reads every result at the next falling edge, half a cycle after the edge that produced it.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_READ, S_COLLECT, S_RDBUF, S_DUMMY
  } seq_state_t;

  typedef enum logic [3:0] {
    K_UNK, K_WEN, K_WDIS, K_STAT, K_ID, K_EAR_RD, K_EAR_WR,
    K_EN4, K_EX4, K_CHIP, K_READ, K_FAST, K_PROG, K_ERASE
  } op_kind_t;

  typedef enum logic [1:0] {E_4K, E_32K, E_SECT, E_CHIP} erase_sz_t;

  typedef struct packed {
    op_kind_t  kind;
    logic [3:0] need;   // bytes to collect after the opcode
    logic       alen4;  // address is 4 bytes wide
    erase_sz_t  esz;
  } op_info_t;

  // Opcode classification: the family, the header length and the address width.
  function automatic op_info_t decode_op(input logic [7:0] op,
                                         input logic four, input logic wide);
    op_info_t d;
    logic [3:0] base;
    base    = four ? 4'd4 : 4'd3;
    d.kind  = K_UNK;
    d.need  = 4'd0;
    d.alen4 = four;
    d.esz   = E_SECT;
    case (op)
      8'h06: d.kind = K_WEN;
      8'h04: d.kind = K_WDIS;
      8'h05: d.kind = K_STAT;
      8'h9F: d.kind = K_ID;
      8'hB7: d.kind = K_EN4;
      8'hE9: d.kind = K_EX4;
      8'hC8: d.kind = K_EAR_RD;
      8'hC5: begin d.kind = K_EAR_WR; d.need = 4'd1; end
      8'h60, 8'hC7: begin d.kind = K_CHIP; d.esz = E_CHIP; end
      8'h03: begin d.kind = K_READ; d.need = base; end
      8'h13: begin d.kind = K_READ; d.need = 4'd4; d.alen4 = 1'b1; end
      8'h0B, 8'h3B, 8'h6B: begin d.kind = K_FAST; d.need = base; end
      8'h0C, 8'h3C, 8'h6C: begin d.kind = K_FAST; d.need = 4'd4; d.alen4 = 1'b1; end
      8'hBB: begin d.kind = K_FAST; d.need = wide ? 4'd5 : 4'd4; end
      8'hBC: begin d.kind = K_FAST; d.need = wide ? 4'd6 : 4'd5; d.alen4 = 1'b1; end
      8'hEB: begin d.kind = K_FAST; d.need = wide ? 4'd8 : 4'd6; end
      8'hEC: begin d.kind = K_FAST; d.need = wide ? 4'd9 : 4'd7; d.alen4 = 1'b1; end
      8'h02, 8'h32, 8'hA2: begin d.kind = K_PROG; d.need = base; end
      8'h12, 8'h34: begin d.kind = K_PROG; d.need = 4'd4; d.alen4 = 1'b1; end
      8'h20: begin d.kind = K_ERASE; d.need = base; d.esz = E_4K; end
      8'h21: begin d.kind = K_ERASE; d.need = 4'd4; d.alen4 = 1'b1; d.esz = E_4K; end
      8'h52: begin d.kind = K_ERASE; d.need = base; d.esz = E_32K; end
      8'hD8: begin d.kind = K_ERASE; d.need = base; end
      8'hDC: begin d.kind = K_ERASE; d.need = 4'd4; d.alen4 = 1'b1; end
      default: ;
    endcase
    return d;
  endfunction

  // Dummy transfers before read data, one per active data line.
  function automatic logic [2:0] dummy_len(input logic [1:0] lanes);
    case (lanes)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/nor_op_decode.sv
module nor_op_decode
  import nor_seq_pkg::*;
(
  input  logic [7:0] op,
  input  logic       four,
  input  logic       wide,
  output op_info_t   info
);
  assign info = decode_op(op, four, wide);
endmodule

// File: rtl/nor_addr_build.sv
module nor_addr_build #(
  parameter int MEM_AW = 26
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        in_addr,
  input  logic [7:0]  byte_in,
  input  logic        alen4,
  input  logic [1:0]  ear_lo,
  output logic [31:0] addr_next
);
  localparam logic [31:0] MASK = 32'((64'd1 << MEM_AW) - 64'd1);

  logic [31:0] acc, acc_n;

  // Header bytes beyond the address are not shifted in.
  assign acc_n = in_addr ? {acc[23:0], byte_in} : acc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    acc <= '0;
    else if (take) acc <= acc_n;

  assign addr_next = (alen4 ? acc_n
                            : ({6'd0, ear_lo, 24'd0} + {8'd0, acc_n[23:0]})) & MASK;
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int          MEM_AW    = 26,
  parameter int          SECT_LOG2 = 16,
  parameter logic [23:0] ID_CODE   = 24'h5A3C17,
  parameter logic [15:0] EXT_ID    = 16'h4D01,
  parameter bit          HAS_EXT   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_start,
  input  logic        byte_valid,
  input  logic [7:0]  byte_in,
  input  logic [1:0]  lanes,
  input  logic        wide_io_hdr,
  output logic [7:0]  resp_out,
  output logic        mem_rd_en,
  output logic        mem_wr_en,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        erase_req,
  output logic [31:0] erase_base,
  output logic [31:0] erase_len
);
  localparam logic [31:0] ADDR_MASK = 32'((64'd1 << MEM_AW) - 64'd1);
  localparam logic [31:0] CHIP_LEN  = 32'(64'd1 << MEM_AW);
  localparam logic [31:0] SECT_LEN  = 32'(64'd1 << SECT_LOG2);
  localparam logic [2:0]  ID_LEN    = HAS_EXT ? 3'd5 : 3'd3;

  seq_state_t  state;
  logic        wel, four;
  logic [7:0]  ear;
  logic [31:0] cur_addr, addr_next;
  logic [3:0]  idx, need;
  op_kind_t    cmd_kind;
  logic        cmd_alen4;
  erase_sz_t   cmd_esz;
  logic [2:0]  dcnt;
  logic        rb_id, rb_loop;
  logic [2:0]  rb_len, rb_pos;
  logic [7:0]  rb_snap;
  op_info_t    dec;

  // Named events for the checker.
  logic step, in_idle, in_read, in_dummy, in_collect, in_rdbuf, ev_unknown, ev_wen;
  assign step       = byte_valid && !cs_start;
  assign in_idle    = (state == S_IDLE);
  assign in_read    = (state == S_READ);
  assign in_dummy   = (state == S_DUMMY);
  assign in_collect = (state == S_COLLECT);
  assign in_rdbuf   = (state == S_RDBUF);
  assign ev_unknown = step && in_idle && (dec.kind == K_UNK);
  assign ev_wen     = step && in_idle && (dec.kind == K_WEN);

  function automatic logic [7:0] id_byte(input logic [2:0] p);
    case (p)
      3'd0: return ID_CODE[23:16];
      3'd1: return ID_CODE[15:8];
      3'd2: return ID_CODE[7:0];
      3'd3: return EXT_ID[15:8];
      3'd4: return EXT_ID[7:0];
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [31:0] region_len(input erase_sz_t e);
    case (e)
      E_4K:    return 32'd4096;
      E_32K:   return 32'd32768;
      E_SECT:  return SECT_LEN;
      default: return CHIP_LEN;
    endcase
  endfunction

  nor_op_decode u_dec (
    .op(byte_in), .four(four), .wide(wide_io_hdr), .info(dec)
  );

  nor_addr_build #(.MEM_AW(MEM_AW)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .take(step && in_collect),
    .in_addr(idx < (cmd_alen4 ? 4'd4 : 4'd3)),
    .byte_in(byte_in), .alen4(cmd_alen4), .ear_lo(ear[1:0]),
    .addr_next(addr_next)
  );

  assign mem_addr  = cur_addr;
  assign mem_wdata = byte_in;
  assign mem_rd_en = step && in_read;
  assign mem_wr_en = step && (state == S_PROG) && wel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  wel <= 1'b0;  four <= 1'b0;  ear <= '0;
      cur_addr <= '0;   idx <= '0;    need <= '0;
      cmd_kind <= K_UNK; cmd_alen4 <= 1'b0; cmd_esz <= E_SECT;
      dcnt <= '0; rb_id <= 1'b0; rb_loop <= 1'b0; rb_len <= '0; rb_pos <= '0;
      rb_snap <= '0; resp_out <= 8'hFF;
      erase_req <= 1'b0; erase_base <= '0; erase_len <= '0;
    end else begin
      erase_req <= 1'b0;
      if (cs_start) begin
        state    <= S_IDLE;
        resp_out <= 8'hFF;
      end else if (byte_valid) begin
        resp_out <= 8'hFF;
        case (state)
          S_IDLE: begin
            case (dec.kind)
              K_WEN:  wel  <= 1'b1;
              K_WDIS: wel  <= 1'b0;
              K_EN4:  four <= 1'b1;
              K_EX4:  four <= 1'b0;
              K_STAT, K_EAR_RD: begin
                rb_snap <= (dec.kind == K_STAT) ? {6'd0, wel, 1'b0} : ear;
                rb_id   <= 1'b0;
                rb_loop <= (dec.kind == K_STAT);
                rb_len  <= 3'd1;
                rb_pos  <= '0;
                state   <= S_RDBUF;
              end
              K_ID: begin
                rb_id <= 1'b1; rb_loop <= 1'b0; rb_len <= ID_LEN; rb_pos <= '0;
                state <= S_RDBUF;
              end
              K_CHIP: if (wel) begin
                erase_req <= 1'b1; erase_base <= '0; erase_len <= CHIP_LEN;
              end
              K_EAR_WR, K_READ, K_FAST, K_PROG, K_ERASE:
                if (dec.kind != K_EAR_WR || wel) begin
                  need      <= dec.need;
                  idx       <= '0;
                  cmd_kind  <= dec.kind;
                  cmd_alen4 <= dec.alen4;
                  cmd_esz   <= dec.esz;
                  state     <= S_COLLECT;
                end
              default: ;
            endcase
          end
          S_COLLECT: begin
            idx <= idx + 4'd1;
            if (idx + 4'd1 == need) begin
              state <= S_IDLE;
              case (cmd_kind)
                K_EAR_WR: ear <= byte_in;
                K_READ:  begin cur_addr <= addr_next; state <= S_READ; end
                K_FAST:  begin cur_addr <= addr_next; dcnt <= dummy_len(lanes); state <= S_DUMMY; end
                K_PROG:  begin cur_addr <= addr_next; state <= S_PROG; end
                K_ERASE: if (wel) begin
                  erase_req <= 1'b1; erase_base <= addr_next; erase_len <= region_len(cmd_esz);
                end
                default: ;
              endcase
            end
          end
          S_DUMMY: begin
            dcnt <= dcnt - 3'd1;
            if (dcnt == 3'd1) state <= S_READ;
          end
          S_READ: begin
            resp_out <= mem_rdata;
            cur_addr <= (cur_addr + 32'd1) & ADDR_MASK;
          end
          S_PROG: cur_addr <= (cur_addr + 32'd1) & ADDR_MASK;
          S_RDBUF: begin
            resp_out <= rb_id ? id_byte(rb_pos) : rb_snap;
            if (rb_pos + 3'd1 == rb_len) begin
              rb_pos <= '0;
              if (!rb_loop) state <= S_IDLE;
            end else begin
              rb_pos <= rb_pos + 3'd1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_start,
  input logic       step,
  input logic       in_idle,
  input logic       in_read,
  input logic       in_dummy,
  input logic       in_collect,
  input logic       in_rdbuf,
  input logic       rb_loop,
  input logic       ev_unknown,
  input logic       ev_wen,
  input logic       wel,
  input logic [7:0] resp_out,
  input logic       mem_rd_en,
  input logic [7:0] mem_rdata,
  input logic       erase_req
);
  AST_CS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> in_idle); // R2
  AST_WEN_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wen |=> wel); // R3
  AST_STATUS_LOOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rdbuf && rb_loop && step) |=> in_rdbuf); // R3
  AST_READ_RETURNS_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (resp_out == $past(mem_rdata))); // R5
  AST_READ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_read) |-> $past(in_collect || in_dummy)); // R7
  AST_ERASE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> wel); // R10
  AST_UNKNOWN_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unknown |=> (in_idle && resp_out == 8'hFF)); // R11
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (.*);

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_start = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic [1:0]  lanes = 2'd0;
  logic        wide_io_hdr = 1'b0;
  logic [7:0]  resp_out;
  logic        mem_rd_en, mem_wr_en, erase_req;
  logic [31:0] mem_addr, erase_base, erase_len;
  logic [7:0]  mem_wdata, mem_rdata;

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  logic [31:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ {6'd0, a[25:24]} ^ 8'h3C;
  endfunction

  assign mem_rdata = pat(mem_addr);

  always @(posedge clk) if (mem_wr_en) begin
    wr_cnt  <= wr_cnt + 1;
    wr_addr <= mem_addr;
    wr_data <= mem_wdata;
  end

  nor_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .byte_valid(byte_valid),
    .byte_in(byte_in), .lanes(lanes), .wide_io_hdr(wide_io_hdr),
    .resp_out(resp_out), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .erase_req(erase_req), .erase_base(erase_base), .erase_len(erase_len)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Called at a falling edge; returns at the next one with the response.
  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    byte_valid = 1'b1;
    byte_in    = b;
    @(negedge clk);
    byte_valid = 1'b0;
    r = resp_out;
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r;
    xfer(b, r);
  endtask

  task automatic sel();
    cs_start = 1'b1;
    @(negedge clk);
    cs_start = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R1 resp after reset", resp_out, 8'hFF);
    check("R1 no erase", erase_req, 1'b0);
    sel(); xfer(8'h05, r);
    check("R12 opcode resp", r, 8'hFF);
    xfer(8'h00, r);
    check("R1 write enable clear", r, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] r;
    sel(); send(8'h06);
    sel(); send(8'h05);
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, r);
      check("R3 status loops with wel", r, 8'h02);
    end
    sel(); send(8'h04);
    sel(); send(8'h05); xfer(8'h00, r);
    check("R3 status after clear", r, 8'h00);
  endtask

  task automatic t_id();
    logic [7:0] r;
    logic [7:0] exp [5] = '{8'h5A, 8'h3C, 8'h17, 8'h4D, 8'h01};
    sel(); send(8'h9F);
    for (int i = 0; i < 5; i++) begin
      xfer(8'h00, r);
      check("R4 id byte", r, exp[i]);
    end
    xfer(8'h05, r);
    check("R4 back to idle", r, 8'hFF);
    xfer(8'h00, r);
    check("R4 next opcode decoded", r, 8'h00);
  endtask

  task automatic t_read();
    logic [7:0] r;
    sel(); send(8'h03); send(8'h12); send(8'h34);
    xfer(8'h56, r);
    check("R12 address resp", r, 8'hFF);
    xfer(8'h00, r); check("R5 read first", r, pat(32'h123456));
    xfer(8'h00, r); check("R5 read increments", r, pat(32'h123457));
  endtask

  task automatic t_ear();
    logic [7:0] r;
    sel(); send(8'h06);
    sel(); send(8'hC5); send(8'h02);
    sel(); send(8'hC8); xfer(8'h00, r);
    check("R6 ext reg readback", r, 8'h02);
    sel(); send(8'h03); send(8'h00); send(8'h00); send(8'h10);
    xfer(8'h00, r);
    check("R6 segment added", r, pat(32'h02000010));
    sel(); send(8'hC5); send(8'h00);
  endtask

  task automatic t_four();
    logic [7:0] r;
    sel(); send(8'hB7);
    sel(); send(8'h03); send(8'h01); send(8'h00); send(8'h00); send(8'h20);
    xfer(8'h00, r); check("R5 4-byte mode read", r, pat(32'h01000020));
    sel(); send(8'hE9);
    sel(); send(8'h13); send(8'h00); send(8'h00); send(8'h00); send(8'h40);
    xfer(8'h00, r); check("R5 0x13 always 4 bytes", r, pat(32'h40));
    sel(); send(8'h03); send(8'h00); send(8'h00); send(8'h41);
    xfer(8'h00, r); check("R5 3-byte after exit", r, pat(32'h41));
  endtask

  task automatic t_fast();
    logic [7:0] r;
    lanes = 2'd0;
    sel(); send(8'h0B); send(8'h00); send(8'h02); send(8'h00);
    xfer(8'h00, r); check("R7 single dummy", r, 8'hFF);
    xfer(8'h00, r); check("R7 single data", r, pat(32'h200));
    lanes = 2'd1;
    sel(); send(8'h3B); send(8'h00); send(8'h02); send(8'h80);
    send(8'h00); xfer(8'h00, r); check("R7 dual second dummy", r, 8'hFF);
    xfer(8'h00, r); check("R7 dual data", r, pat(32'h280));
    lanes = 2'd2;
    sel(); send(8'h6B); send(8'h00); send(8'h03); send(8'h00);
    send(8'h00); send(8'h00); send(8'h00);
    xfer(8'h00, r); check("R7 quad fourth dummy", r, 8'hFF);
    xfer(8'h00, r); check("R7 quad data", r, pat(32'h300));
  endtask

  task automatic t_dio();
    logic [7:0] r;
    wide_io_hdr = 1'b0; lanes = 2'd1;
    sel(); send(8'hBB); send(8'h00); send(8'h04); send(8'h00); send(8'hA5);
    send(8'h00); xfer(8'h00, r); check("R8 dual io dummy", r, 8'hFF);
    xfer(8'h00, r); check("R8 dual io 4-byte header", r, pat(32'h400));
    wide_io_hdr = 1'b1; lanes = 2'd2;
    sel(); send(8'hEB); send(8'h00); send(8'h05); send(8'h00);
    for (int i = 0; i < 5; i++) send(8'h5A);
    for (int i = 0; i < 4; i++) send(8'h00);
    xfer(8'h00, r); check("R8 quad io 8-byte header", r, pat(32'h500));
    wide_io_hdr = 1'b0; lanes = 2'd0;
    sel(); send(8'hBC); send(8'h00); send(8'h00); send(8'h06); send(8'h00); send(8'hC3);
    send(8'h00);
    xfer(8'h00, r); check("R8 dual io 4-byte form", r, pat(32'h600));
  endtask

  task automatic t_prog();
    int base_cnt;
    sel(); send(8'h04);
    base_cnt = wr_cnt;
    sel(); send(8'h02); send(8'h00); send(8'h01); send(8'h00); send(8'hAA);
    check("R9 no write without wel", wr_cnt, base_cnt);
    sel(); send(8'h06);
    sel(); send(8'h02); send(8'h00); send(8'h01); send(8'h00); send(8'hAA);
    check("R9 first write addr", wr_addr, 32'h100);
    check("R9 first write data", wr_data, 8'hAA);
    send(8'h55);
    check("R9 second write addr", wr_addr, 32'h101);
    check("R9 write count", wr_cnt, base_cnt + 2);
  endtask

  task automatic t_erase();
    sel(); send(8'h04);
    sel(); send(8'hD8); send(8'h00); send(8'h10); send(8'h00);
    check("R10 no erase without wel", erase_req, 1'b0);
    sel(); send(8'h06);
    sel(); send(8'h20); send(8'h01); send(8'h23); send(8'h45);
    check("R10 4K request", erase_req, 1'b1);
    check("R10 4K base", erase_base, 32'h012345);
    check("R10 4K len", erase_len, 32'd4096);
    @(negedge clk);
    check("R10 one-cycle pulse", erase_req, 1'b0);
    sel(); send(8'hDC); send(8'h00); send(8'h02); send(8'h00); send(8'h00);
    check("R10 sector len", erase_len, 32'h10000);
    check("R10 sector base", erase_base, 32'h20000);
    sel(); send(8'hC7);
    check("R10 chip request", erase_req, 1'b1);
    check("R10 chip len", erase_len, 32'h04000000);
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    sel(); xfer(8'h42, r);
    check("R11 unknown resp", r, 8'hFF);
    xfer(8'h05, r);
    check("R11 next is opcode", r, 8'hFF);
    xfer(8'h00, r);
    check("R11 status after unknown", r, 8'h02);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    sel(); send(8'h03); send(8'h00); send(8'h00); send(8'h07);
    xfer(8'h00, r); check("R2 read before abort", r, pat(32'h7));
    sel(); xfer(8'h05, r);
    check("R2 decoded after cs", r, 8'hFF);
    xfer(8'h00, r);
    check("R2 wel kept", r, 8'h02);
  endtask

  task automatic t_wrap();
    logic [7:0] r;
    sel(); send(8'h13); send(8'h03); send(8'hFF); send(8'hFF); send(8'hFF);
    xfer(8'h00, r); check("R5 top address", r, pat(32'h03FFFFFF));
    xfer(8'h00, r); check("R5 wrap to zero", r, pat(32'h0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_id();
    t_read();
    t_ear();
    t_four();
    t_fast();
    t_dio();
    t_prog();
    t_erase();
    t_unknown();
    t_abort();
    t_wrap();
    summary();
  end
endmodule